// File: doc/BRIEF.md
# Host-to-DSP Byte Mailbox

This block links an 8-bit host processor bus to the 24-bit peripheral bus of a signal-processing core. The host sees eight byte registers: an interrupt control byte, a command vector byte, a read-only status byte, an interrupt vector byte, and a four-byte data window. The core sees one status byte, a 24-bit receive word and a 24-bit transmit word. Host bytes are staged and packed into a word for the core. Core words are split into bytes for the host.

Both directions move a word on their own as soon as the flags allow it. Host to core needs the host transmit buffer full and the core receive buffer empty. Core to host needs the core transmit buffer full and the host receive buffer empty. All state changes on one clock edge. Within that edge, the host access is applied first, then the core access, and then any transfer that has become possible. Read data is combinational from the current state, so a read returns the value from before the edge.

Top module: `host_dsp_mailbox`

## Requirements
- R1: After reset, the host bytes read as follows: offset 0 (interrupt control) = 0x00, offset 1 (command vector) = 0x12, offset 2 (status) = 0x06, offset 3 (interrupt vector) = 0x0F. The core status is 0x02 and the core receive word is 0.
- R2: A host write to offset 0 stores the value ANDed with 0xFB. Its bits 3 and 4 (host flags) appear at bits 3 and 4 of the core status from the next cycle on.
- R3: A host write to offset 1 stores the value ANDed with 0x9F. A written bit 7 of 1 sets core status bit 2 (command pending), which stays set until reset.
- R4: Host writes to offset 2 (status) and offset 4 (window pad) change nothing that is visible.
- R5: A host write to offset 3 stores the full byte.
- R6: Host writes to offsets 5, 6 and 7 give the high, middle and low byte of the word. A write to offset 7 while core status bit 0 (receive full) is 0 loads the core receive word with {high, middle, low} on that edge. It also sets receive full and leaves host status bit 1 (transmit empty) at 1.
- R7: A write to offset 7 while receive full is 1 clears transmit empty and holds the word. A core receive read (dspRdRx) then clears receive full and delivers the held word on the same edge.
- R8: Host status bit 2 (transmit ready) always equals transmit empty AND NOT receive full.
- R9: A core transmit write (dspWrTx) stores the word and clears core status bit 1 (transmit empty). While host status bit 0 (receive full) is 0, the word moves on the same edge into host offsets 5, 6 and 7 (high, middle, low), and both flags are set.
- R10: A host read of offset 7 clears host receive full on that edge, and a held core word then moves at once. Reading offset 4 always returns 0.
- R11: When host and core access in the same cycle, the host access is applied first, then the core access, then the transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostAddr | input | 3 | Host register offset |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe |
| hostWrData | input | 8 | Host write byte |
| hostRdData | output | 8 | Host read byte, combinational |
| dspRdRx | input | 1 | Core reads the receive word |
| dspWrTx | input | 1 | Core writes the transmit word |
| dspTxData | input | 24 | Core transmit word |
| dspRxData | output | 24 | Core receive word |
| dspStatus | output | 8 | Core status: bit0 receive full, bit1 transmit empty, bit2 command pending, bits3-4 host flags |

## Verification
Every access takes effect on the next rising edge. The flags, the core receive word and the host receive bytes are therefore due one cycle after the stimulus. Host read data reflects the state before that edge. The bench drives each access at the falling edge and samples the outputs one nanosecond later, before the rising edge that consumes the access. It compares them with a model that applies the same host-first ordering on that edge, so every expectation refers to the state left by the previous cycle.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 24;
  localparam int LANES  = WORD_W / BYTE_W;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFS_ICR = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_CVR = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_ISR = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_IVR = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_PAD = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_HI  = 3'd5;
  localparam logic [ADDR_W-1:0] OFS_MID = 3'd6;
  localparam logic [ADDR_W-1:0] OFS_LO  = 3'd7;

  localparam logic [BYTE_W-1:0] ICR_MASK  = 8'hFB;
  localparam logic [BYTE_W-1:0] CVR_MASK  = 8'h9F;
  localparam logic [BYTE_W-1:0] CVR_RESET = 8'h12;
  localparam logic [BYTE_W-1:0] IVR_RESET = 8'h0F;
  localparam int CMD_BIT   = 7;
  localparam int FLAG0_BIT = 3;
  localparam int FLAG1_BIT = 4;

  typedef struct packed {
    logic             loadIcr;
    logic             loadCvr;
    logic             loadIvr;
    logic [LANES-1:0] loadTx;
    logic             loadDspTx;
    logic             hostToDsp;
    logic             dspToHost;
  } strobe_t;
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic              cmdBit,
  input  logic              dspRdRx,
  input  logic              dspWrTx,
  output strobe_t           stb,
  output logic              rxFull,
  output logic              txEmpty,
  output logic              dspRxFull,
  output logic              dspTxEmpty,
  output logic              cmdPending
);
  logic lowWr, lowRd;
  logic txEmptyMid, rxFullMid, dspRxFullMid, dspTxEmptyMid;

  assign lowWr = hostWr && (hostAddr == OFS_LO);
  assign lowRd = hostRd && (hostAddr == OFS_LO);

  assign stb.loadIcr   = hostWr && (hostAddr == OFS_ICR);
  assign stb.loadCvr   = hostWr && (hostAddr == OFS_CVR);
  assign stb.loadIvr   = hostWr && (hostAddr == OFS_IVR);
  assign stb.loadDspTx = dspWrTx;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign stb.loadTx[i] = hostWr && (hostAddr == ADDR_W'(OFS_LO - i));
  end

  // host access first, then core access, then transfers
  assign txEmptyMid    = lowWr ? 1'b0 : txEmpty;
  assign rxFullMid     = lowRd ? 1'b0 : rxFull;
  assign dspRxFullMid  = dspRdRx ? 1'b0 : dspRxFull;
  assign dspTxEmptyMid = dspWrTx ? 1'b0 : dspTxEmpty;

  assign stb.hostToDsp = !txEmptyMid && !dspRxFullMid;
  assign stb.dspToHost = !rxFullMid && !dspTxEmptyMid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txEmpty    <= 1'b1;
      rxFull     <= 1'b0;
      dspRxFull  <= 1'b0;
      dspTxEmpty <= 1'b1;
      cmdPending <= 1'b0;
    end else begin
      txEmpty    <= stb.hostToDsp ? 1'b1 : txEmptyMid;
      dspRxFull  <= stb.hostToDsp ? 1'b1 : dspRxFullMid;
      rxFull     <= stb.dspToHost ? 1'b1 : rxFullMid;
      dspTxEmpty <= stb.dspToHost ? 1'b1 : dspTxEmptyMid;
      if (stb.loadCvr && cmdBit) cmdPending <= 1'b1;
    end
  end

  p_move_when_room_r6: assert property (@(posedge clk) disable iff (!rstN)
    (lowWr && !dspRxFull) |=> (dspRxFull && txEmpty));
  p_hold_when_full_r7: assert property (@(posedge clk) disable iff (!rstN)
    (lowWr && dspRxFull && !dspRdRx) |=> !txEmpty);
  p_cmd_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmdPending |=> cmdPending);
  p_core_word_moves_r9: assert property (@(posedge clk) disable iff (!rstN)
    (dspWrTx && !rxFull) |=> (rxFull && dspTxEmpty));
endmodule

// File: rtl/mbox_dpath.sv
module mbox_dpath
  import mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [BYTE_W-1:0] hostWrData,
  input  logic [WORD_W-1:0] dspTxData,
  input  logic              rxFull,
  input  logic              txEmpty,
  input  logic              dspRxFull,
  output logic [BYTE_W-1:0] hostRdData,
  output logic [WORD_W-1:0] dspRxData,
  output logic [1:0]        hostFlags
);
  logic [BYTE_W-1:0] icrQ, cvrQ, ivrQ, isrByte;
  logic [WORD_W-1:0] txWordQ, txWordNext, hostRxQ, dspRxQ, dspTxQ, dspTxNext;

  for (genvar i = 0; i < LANES; i++) begin : g_pack
    assign txWordNext[i*BYTE_W +: BYTE_W] =
      stb.loadTx[i] ? hostWrData : txWordQ[i*BYTE_W +: BYTE_W];
  end
  assign dspTxNext = stb.loadDspTx ? dspTxData : dspTxQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      icrQ    <= '0;
      cvrQ    <= CVR_RESET;
      ivrQ    <= IVR_RESET;
      txWordQ <= '0;
      hostRxQ <= '0;
      dspRxQ  <= '0;
      dspTxQ  <= '0;
    end else begin
      if (stb.loadIcr) icrQ <= hostWrData & ICR_MASK;
      if (stb.loadCvr) cvrQ <= hostWrData & CVR_MASK;
      if (stb.loadIvr) ivrQ <= hostWrData;
      txWordQ <= txWordNext;
      dspTxQ  <= dspTxNext;
      if (stb.hostToDsp) dspRxQ  <= txWordNext;
      if (stb.dspToHost) hostRxQ <= dspTxNext;
    end
  end

  assign isrByte = {5'b0, txEmpty & ~dspRxFull, txEmpty, rxFull};

  always_comb begin
    unique case (hostAddr)
      OFS_ICR: hostRdData = icrQ;
      OFS_CVR: hostRdData = cvrQ;
      OFS_ISR: hostRdData = isrByte;
      OFS_IVR: hostRdData = ivrQ;
      OFS_PAD: hostRdData = '0;
      OFS_HI:  hostRdData = hostRxQ[2*BYTE_W +: BYTE_W];
      OFS_MID: hostRdData = hostRxQ[BYTE_W +: BYTE_W];
      default: hostRdData = hostRxQ[0 +: BYTE_W];
    endcase
  end

  assign dspRxData = dspRxQ;
  assign hostFlags = {icrQ[FLAG1_BIT], icrQ[FLAG0_BIT]};

  p_ivr_full_byte_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadIvr |=> (ivrQ == $past(hostWrData)));
  p_icr_bit2_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadIcr |=> ((icrQ & ~ICR_MASK) == '0));
endmodule

// File: rtl/host_dsp_mailbox.sv
module host_dsp_mailbox
  import mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [BYTE_W-1:0] hostWrData,
  output logic [BYTE_W-1:0] hostRdData,
  input  logic              dspRdRx,
  input  logic              dspWrTx,
  input  logic [WORD_W-1:0] dspTxData,
  output logic [WORD_W-1:0] dspRxData,
  output logic [BYTE_W-1:0] dspStatus
);
  strobe_t    stb;
  logic       rxFull, txEmpty, dspRxFull, dspTxEmpty, cmdPending;
  logic [1:0] hostFlags;

  mbox_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr), .hostRd(hostRd),
    .cmdBit(hostWrData[CMD_BIT]), .dspRdRx(dspRdRx), .dspWrTx(dspWrTx), .stb(stb),
    .rxFull(rxFull), .txEmpty(txEmpty), .dspRxFull(dspRxFull),
    .dspTxEmpty(dspTxEmpty), .cmdPending(cmdPending)
  );

  mbox_dpath u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .hostAddr(hostAddr), .hostWrData(hostWrData),
    .dspTxData(dspTxData), .rxFull(rxFull), .txEmpty(txEmpty), .dspRxFull(dspRxFull),
    .hostRdData(hostRdData), .dspRxData(dspRxData), .hostFlags(hostFlags)
  );

  assign dspStatus = {3'b0, hostFlags, cmdPending, dspTxEmpty, dspRxFull};
endmodule

// File: tb/host_dsp_mailbox_bench.sv
module host_dsp_mailbox_bench;
  logic        clk = 0, rstN = 0;
  logic [2:0]  hostAddr = 0;
  logic        hostWr = 0, hostRd = 0, dspRdRx = 0, dspWrTx = 0;
  logic [7:0]  hostWrData = 0, hostRdData, dspStatus;
  logic [23:0] dspTxData = 0, dspRxData;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0]  mIcr, mCvr, mIvr;
  logic [23:0] mTx, mRx, mDrx, mDtx;
  bit          mRxdf, mTxde, mHrdf, mHtde, mHcp;

  host_dsp_mailbox u_host_dsp_mailbox (.*);

  always #5 clk = ~clk;

  function automatic logic [7:0] expRead(input logic [2:0] a);
    case (a)
      3'd0: return mIcr;
      3'd1: return mCvr;
      3'd2: return {5'b0, mTxde & ~mHrdf, mTxde, mRxdf};
      3'd3: return mIvr;
      3'd4: return 8'h00;
      3'd5: return mRx[23:16];
      3'd6: return mRx[15:8];
      default: return mRx[7:0];
    endcase
  endfunction

  function automatic logic [7:0] expStat();
    return {3'b0, mIcr[4], mIcr[3], mHcp, mHtde, mHrdf};
  endfunction

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    mIcr = 0; mCvr = 8'h12; mIvr = 8'h0F; mTx = 0; mRx = 0; mDrx = 0; mDtx = 0;
    mRxdf = 0; mTxde = 1; mHrdf = 0; mHtde = 1; mHcp = 0;
  endtask

  task automatic step(input string tag, input bit wr, input bit rd, input logic [2:0] a,
                      input logic [7:0] d, input bit dr, input bit dw, input logic [23:0] dd);
    @(negedge clk);
    hostWr = wr; hostRd = rd; hostAddr = a; hostWrData = d;
    dspRdRx = dr; dspWrTx = dw; dspTxData = dd;
    #1;
    if (rd) chk({tag, " host read"}, {16'b0, hostRdData}, {16'b0, expRead(a)});
    chk({tag, " core status"}, {16'b0, dspStatus}, {16'b0, expStat()});
    chk({tag, " core rx word"}, dspRxData, mDrx);
    // R11: host access, then core access, then transfers
    if (wr) case (a)
      3'd0: mIcr = d & 8'hFB;
      3'd1: begin mCvr = d & 8'h9F; if (d[7]) mHcp = 1; end
      3'd3: mIvr = d;
      3'd5: mTx[23:16] = d;
      3'd6: mTx[15:8] = d;
      3'd7: begin mTx[7:0] = d; mTxde = 0; end
      default: ;
    endcase
    if (rd && a == 3'd7) mRxdf = 0;
    if (dr) mHrdf = 0;
    if (dw) begin mHtde = 0; mDtx = dd; end
    if (!mTxde && !mHrdf) begin mDrx = mTx; mHrdf = 1; mTxde = 1; end
    if (!mRxdf && !mHtde) begin mRx = mDtx; mRxdf = 1; mHtde = 1; end
  endtask

  task automatic hw(input string tag, input logic [2:0] a, input logic [7:0] d);
    step(tag, 1, 0, a, d, 0, 0, 0);
  endtask
  task automatic hr(input string tag, input logic [2:0] a);
    step(tag, 0, 1, a, 0, 0, 0, 0);
  endtask
  task automatic readAll(input string tag);
    for (int k = 0; k < 8; k++) hr(tag, 3'(k));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1;
    readAll("R1 reset");
    readAll("R10 pad reads zero");
    hw("R2 icr", 3'd0, 8'hFF);  hr("R2 icr", 3'd0);
    hw("R2 icr", 3'd0, 8'h08);  hr("R2 icr", 3'd0);
    hw("R3 cvr", 3'd1, 8'h55);  hr("R3 cvr", 3'd1);
    hw("R3 cvr", 3'd1, 8'h80);  hr("R3 cvr", 3'd1);
    hw("R3 cvr", 3'd1, 8'h01);  hr("R3 sticky", 3'd1);
    hw("R4 isr", 3'd2, 8'h00);  hw("R4 pad", 3'd4, 8'hFF);  readAll("R4 ignored");
    hw("R5 ivr", 3'd3, 8'hA5);  hr("R5 ivr", 3'd3);
    hw("R6 word", 3'd5, 8'h12); hw("R6 word", 3'd6, 8'h34); hw("R6 word", 3'd7, 8'h56);
    hr("R6 flags", 3'd2);
    hw("R7 word", 3'd5, 8'hAB); hw("R7 word", 3'd6, 8'hCD); hw("R7 word", 3'd7, 8'hEF);
    hr("R8 trdy low", 3'd2);
    step("R7 core read", 0, 0, 0, 0, 1, 0, 0);
    hr("R8 trdy", 3'd2);
    step("R8 core read", 0, 0, 0, 0, 1, 0, 0);
    hr("R8 trdy high", 3'd2);
    step("R9 core write", 0, 0, 0, 0, 0, 1, 24'h0A0B0C);
    hr("R9 hi", 3'd5); hr("R9 mid", 3'd6); hr("R9 flags", 3'd2);
    step("R9 held", 0, 0, 0, 0, 0, 1, 24'h111213);
    hr("R10 read low", 3'd7); hr("R10 moved", 3'd7); hr("R10 hi", 3'd5);
    hw("R11 a", 3'd7, 8'h77); hw("R11 b", 3'd7, 8'h99);
    step("R11 same cycle", 1, 0, 3'd7, 8'h42, 1, 0, 0);
    step("R11 same cycle", 0, 1, 3'd7, 0, 0, 1, 24'hC0FFEE);
    hr("R11 check", 3'd7);
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = $urandom;
      step("R11 random", r[0] & r[1], r[2], r[5:3], r[13:6], r[14] & r[15], r[16] & r[17],
           {r[31:18], r[9:0]});
    end
    step("idle", 0, 0, 0, 0, 0, 0, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule